// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus-facing side of a byte-addressed serial memory that answers on a two-wire, open-drain bus. The bus lines SCL and SDA are sampled on a fast system clock. The block decodes start and stop conditions and checks the device address byte against a fixed prefix and three strap inputs. It then acknowledges and carries out the transaction. Writes load a 16-bit word address and then stream data bytes to a separate page-write engine. Reads fetch bytes from a byte array through a combinational read port and shift them out MSB first.

A single 16-bit address counter lives across transactions. A write header sets it, data bytes step it within the current 128-byte page, and read bytes step it across the whole array. A current-address read therefore continues from where the last access stopped. A random read is a write header with no data, followed by a repeated start in read mode. While the page-write engine reports busy, the target does not acknowledge its device address. A controller can use this to poll for completion.

Top module: `twi_eep_target`

## Requirements
- R1: An SDA fall while SCL is high (start) restarts device-address reception from any state, including partway through a byte. An SDA rise while SCL is high (stop) returns the target to idle with SDA released.
- R2: The device address byte arrives MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal `addr_sel_i`. Bit 0 set to 1 selects a read. On a match the target pulls SDA low for the ninth clock. On a mismatch it does not, and it stays silent until the next start.
- R3: In write mode, two word-address bytes follow, high byte first, and each is acknowledged. The counter takes the 16-bit value only after the second byte is complete.
- R4: Each write data byte is acknowledged and presented once on `wr_en_o`/`wr_addr_o`/`wr_data_o`. Address bits 6..0 then step by one and wrap inside the page, while bits 15..7 are kept.
- R5: `wr_commit_o` pulses for one cycle at a stop only if the transaction delivered at least one data byte.
- R6: While `wr_busy_i` is high, a matching device address is not acknowledged. Once it is low, the address is acknowledged again.
- R7: A read shifts out the byte at the counter address MSB first, changing SDA only after SCL falls. The counter steps by one after every byte sent.
- R8: A random read (write header, repeated start, read address) returns data from the loaded address and issues no write and no commit.
- R9: A read continues while the controller acknowledges each byte. The address wraps from 0xFFFF to 0x0000.
- R10: A missing controller acknowledge ends the read. The target then leaves SDA released on every following clock until a start.
- R11: The counter persists between transactions. After a page write, a current-address read starts at the in-page address following the last written byte.
- R12: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel_i | input | 3 | Strap value compared with device address bits 3..1 |
| wr_busy_i | input | 1 | Page-write engine is committing data |
| rd_addr_o | output | 16 | Read port address (the address counter) |
| rd_data_i | input | 8 | Read port data for `rd_addr_o` |
| wr_en_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | 16 | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the write cycle |

## Verification
The bench first writes three bytes starting two bytes before a page end. A design that carries into bit 7 would put the third byte on the next page and make the follow-on current read return the wrong byte. It then starts a sequential read at 0xFFFE and runs it past the top of the array. A counter that saturated or failed to wrap would repeat 0xFFFF instead of returning address 0. It also polls during the busy window, aborts a device byte with a mid-byte start, and stops after only the high word-address byte. These catch a target that acknowledges while busy, resumes a half-received byte, or commits or loads a partial header. Finally, nine extra clocks follow a read that the controller did not acknowledge; a target still driving would corrupt them.

// File: rtl/twi_eep_pkg.sv
// Package: shared constants and the protocol state type of the two-wire
// memory target. Assumes 8-bit bus bytes.
package twi_eep_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for a start
        ST_DEV,       // shifting in the device address
        ST_WHI,       // shifting in the high word-address byte
        ST_WLO,       // shifting in the low word-address byte
        ST_WDAT,      // shifting in write data
        ST_ACK_WAIT,  // byte received, wait for SCL low to drive ack
        ST_ACK_HOLD,  // ack driven, wait for SCL low to release
        ST_RLOAD,     // controller acked, load next byte on SCL low
        ST_RDAT,      // shifting out read data
        ST_RACK       // waiting for controller ack bit
    } st_e;
endpackage

// File: rtl/twi_eep_sync.sv
// Module: two-wire line conditioner. Brings SCL and SDA into the clk domain
// through a STAGES-deep synchronizer, then derives SCL edges and start/stop
// events. Assumes the bus is idle-high and SCL is far slower than clk.
module twi_eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains plus one history stage, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/twi_eep_addr_ctr.sv
// Module: persistent word-address counter. A load takes a new address; an
// in-page step wraps the low PAGE_BITS only; a linear step wraps the whole
// space. Assumes the three controls come from one decoder; load wins.
module twi_eep_addr_ctr #(
    parameter int AW        = 16,
    parameter int PAGE_BITS = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_page,
    input  logic          step_lin,
    output logic [AW-1:0] cnt_o
);
    // Counter update with load priority over both step kinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load) begin
            cnt_o <= load_val;
        end else if (step_page) begin
            cnt_o <= {cnt_o[AW-1:PAGE_BITS], cnt_o[PAGE_BITS-1:0] + PAGE_BITS'(1)};
        end else if (step_lin) begin
            cnt_o <= cnt_o + AW'(1);
        end
    end

    // R3: a completed header sets the counter exactly.
    a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_o == $past(load_val)));

    // R9: a read step adds one with full-range wrap.
    a_r9_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_lin && !load && !step_page) |=> (cnt_o == $past(cnt_o) + AW'(1)));

    // R4: a write step keeps the page bits.
    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_page && !load) |=> (cnt_o[AW-1:PAGE_BITS] == $past(cnt_o[AW-1:PAGE_BITS])));
endmodule

// File: rtl/twi_eep_target.sv
// Module: two-wire serial memory target. Decodes device address, word
// address and data bytes, drives acknowledges and read data on an
// open-drain enable, streams writes to a page-write engine and reads from a
// combinational read port. Assumes rd_data_i follows rd_addr_o within a
// few clk cycles and that SCL phases last many clk cycles.
module twi_eep_target
    import twi_eep_pkg::*;
#(
    parameter int AW          = 16,
    parameter int PAGE_BITS   = 7,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [SEL_W-1:0]  addr_sel_i,
    input  logic              wr_busy_i,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_commit_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    st_e                st, st_after;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0]  rx_sh;
    logic [BYTE_W-1:0]  rx_byte;
    logic [BYTE_W-1:0]  tx_sh;
    logic [BYTE_W-1:0]  hi_q;
    logic               wrote_q;
    logic               dev_hit;
    logic               byte_done;
    logic               ctr_load, ctr_step_page, ctr_step_lin;
    logic [AW-1:0]      ctr_q;
    logic [AW-1:0]      ld_val;

    twi_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_eep_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_val  (ld_val),
        .step_page (ctr_step_page),
        .step_lin  (ctr_step_lin),
        .cnt_o     (ctr_q)
    );

    assign rd_addr_o = ctr_q;
    assign rx_byte   = {rx_sh, sda_lvl};
    assign ld_val    = AW'({hi_q, rx_byte});

    // Byte-level decode feeding the FSM and the address counter.
    always_comb begin
        dev_hit       = (rx_byte[7:4] == DEV_PREFIX) && (rx_byte[3:1] == addr_sel_i) && !wr_busy_i;
        byte_done     = scl_rise && (bit_cnt == LAST_BIT) && !start_det && !stop_det;
        ctr_load      = byte_done && (st == ST_WLO);
        ctr_step_page = byte_done && (st == ST_WDAT);
        ctr_step_lin  = scl_fall && (st == ST_RDAT) && (bit_cnt == '0) && !start_det && !stop_det;
    end

    // Protocol FSM: start/stop first, then per-state SCL edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            st_after    <= ST_IDLE;
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            hi_q        <= '0;
            wrote_q     <= 1'b0;
            sda_oe_o    <= 1'b0;
            wr_en_o     <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            wr_commit_o <= 1'b0;
        end else begin
            wr_en_o     <= 1'b0;
            wr_commit_o <= 1'b0;
            if (stop_det) begin
                st          <= ST_IDLE;
                sda_oe_o    <= 1'b0;
                wr_commit_o <= wrote_q;
                wrote_q     <= 1'b0;
            end else if (start_det) begin
                st       <= ST_DEV;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV, ST_WHI, ST_WLO, ST_WDAT: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte[BYTE_W-2:0];
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (bit_cnt == LAST_BIT) begin
                                st <= ST_ACK_WAIT;
                                case (st)
                                    ST_DEV: begin
                                        if (dev_hit) st_after <= rx_byte[0] ? ST_RDAT : ST_WHI;
                                        else         st       <= ST_IDLE;
                                    end
                                    ST_WHI: begin
                                        hi_q     <= rx_byte;
                                        st_after <= ST_WLO;
                                    end
                                    ST_WLO: st_after <= ST_WDAT;
                                    default: begin
                                        wr_en_o   <= 1'b1;
                                        wr_addr_o <= ctr_q;
                                        wr_data_o <= rx_byte;
                                        wrote_q   <= 1'b1;
                                        st_after  <= ST_WDAT;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b1;
                            st       <= ST_ACK_HOLD;
                        end
                    end
                    ST_ACK_HOLD: begin
                        if (scl_fall) begin
                            st <= st_after;
                            if (st_after == ST_RDAT) begin
                                tx_sh    <= {rd_data_i[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                                bit_cnt  <= CNT_W'(1);
                            end else begin
                                sda_oe_o <= 1'b0;
                                bit_cnt  <= '0;
                            end
                        end
                    end
                    ST_RLOAD: begin
                        if (scl_fall) begin
                            tx_sh    <= {rd_data_i[BYTE_W-2:0], 1'b0};
                            sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            bit_cnt  <= CNT_W'(1);
                            st       <= ST_RDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (bit_cnt == '0) begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_RACK;
                            end else begin
                                sda_oe_o <= ~tx_sh[BYTE_W-1];
                                tx_sh    <= tx_sh << 1;
                                bit_cnt  <= bit_cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) st <= sda_lvl ? ST_IDLE : ST_RLOAD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Checker state: last strobed write address within one transaction.
    logic [AW-1:0] chk_last_wa;
    logic          chk_wr_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last_wa <= '0;
            chk_wr_seen <= 1'b0;
        end else if (start_det || stop_det) begin
            chk_wr_seen <= 1'b0;
        end else if (wr_en_o) begin
            chk_wr_seen <= 1'b1;
            chk_last_wa <= wr_addr_o;
        end
    end

    // R4: consecutive write strobes step within the page.
    a_r4_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && chk_wr_seen) |->
        ((wr_addr_o[AW-1:PAGE_BITS] == chk_last_wa[AW-1:PAGE_BITS]) &&
         (wr_addr_o[PAGE_BITS-1:0] == chk_last_wa[PAGE_BITS-1:0] + PAGE_BITS'(1))));

    // R1: a start restarts address reception with SDA released.
    a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_DEV && bit_cnt == '0 && !sda_oe_o));

    // R1: a stop returns to idle.
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe_o));

    // R5: a commit only follows a stop.
    a_r5_commit_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_det));

    // R6: no data reaches the engine while it is busy.
    a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !wr_busy_i);

    // R10: a missing controller ack leaves the target idle and released.
    a_r10_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK && scl_rise && sda_lvl && !start_det && !stop_det) |=>
        (st == ST_IDLE && !sda_oe_o));

    // R12: drive enable moves only while SCL is low.
    a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!$past(scl_lvl) || $past(start_det || stop_det)));
endmodule

// File: tb/twi_eep_target_tb.sv
// Bench: bit-level bus controller driving the target; a scoreboard queue
// holds expected write strobes that a monitor pops and compares.
module twi_eep_target_tb;
    localparam int Q    = 10;
    localparam int H    = 20;
    localparam int BUSY = 3000;
    localparam logic [2:0] SEL  = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic sda_oe;
    logic wr_busy = 1'b0;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic wr_en, wr_commit;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_commit = 0;
    int busy_cnt = 0;
    int r12_bad = 0;
    logic prev_oe = 1'b0;
    logic [23:0] exp_q[$];
    logic [23:0] e;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] + a[15:8] * 8'd7 + 8'h11;
    endfunction

    assign sda_bus = !(m_low || sda_oe);
    assign rd_data = mem_f(rd_addr);

    twi_eep_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .addr_sel_i  (SEL),
        .wr_busy_i   (wr_busy),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start;
        m_low = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_low = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic b_stop;
        m_low = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_low = 1'b0; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wt(Q); scl = 1'b1; wt(H/2); b = sda_bus; wt(H/2); scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            d = {d[6:0], b};
        end
        send_bit(!mack);
    endtask

    // Monitor and page-write engine model: pop expected strobes, time busy.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected write strobe", {8'h0, wr_addr, wr_data}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_data} == e, "R4 write strobe addr/data", {8'h0, wr_addr, wr_data}, {8'h0, e});
                end
            end
            if (wr_commit) begin
                n_commit++;
                busy_cnt = BUSY;
            end
            if (busy_cnt > 0) busy_cnt--;
            wr_busy = (busy_cnt != 0);
            if ((sda_oe !== prev_oe) && scl) r12_bad++;
            prev_oe = sda_oe;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ack;
        logic b;
        logic [7:0] d;
        int polls;
        int ones;
        wt(10);
        rst_n = 1'b1;
        wt(4);
        // R1: reset state, line released and no strobes
        chk(!sda_oe && !wr_en && !wr_commit, "R1 reset outputs", {sda_oe, wr_en, wr_commit}, 0);

        // R2: strap mismatch is not acknowledged
        b_start; send_byte(8'hA0, ack); b_stop;
        chk(!ack, "R2 strap mismatch nack", ack, 0);
        // R2: wrong prefix is not acknowledged
        b_start; send_byte({4'b1011, SEL, 1'b0}, ack); b_stop;
        chk(!ack, "R2 prefix mismatch nack", ack, 0);

        // R3/R4: page write across the page end at 0x127E
        b_start;
        send_byte(DEVW, ack); chk(ack, "R2 match ack", ack, 1);
        send_byte(8'h12, ack); chk(ack, "R3 high address ack", ack, 1);
        send_byte(8'h7E, ack); chk(ack, "R3 low address ack", ack, 1);
        exp_q.push_back({16'h127E, 8'hC1});
        send_byte(8'hC1, ack); chk(ack, "R4 data ack 1", ack, 1);
        exp_q.push_back({16'h127F, 8'hC2});
        send_byte(8'hC2, ack); chk(ack, "R4 data ack 2", ack, 1);
        exp_q.push_back({16'h1200, 8'hC3});
        send_byte(8'hC3, ack); chk(ack, "R4 data ack 3 after wrap", ack, 1);
        b_stop; wt(5);
        chk(n_commit == 1, "R5 commit after data", n_commit, 1);
        chk(exp_q.size() == 0, "R4 all strobes seen", exp_q.size(), 0);

        // R6: busy poll
        b_start; send_byte(DEVW, ack); b_stop;
        chk(!ack, "R6 nack while busy", ack, 0);
        polls = 1;
        while (!ack && polls < 40) begin
            b_start; send_byte(DEVW, ack); b_stop;
            polls++;
        end
        chk(ack && polls > 1, "R6 ack after busy ends", polls, 2);
        chk(n_commit == 1, "R5 no commit without data", n_commit, 1);

        // R7/R11: current read continues after page write
        b_start; send_byte(DEVR, ack); recv_byte(1'b0, d); b_stop;
        chk(ack, "R7 read address ack", ack, 1);
        chk(d == mem_f(16'h1201), "R11 current read after write", d, mem_f(16'h1201));

        // R8/R9: random read at 0xFFFE with wrap
        b_start; send_byte(DEVW, ack); send_byte(8'hFF, ack); send_byte(8'hFE, ack);
        b_start; send_byte(DEVR, ack);
        chk(ack, "R8 repeated start read ack", ack, 1);
        recv_byte(1'b1, d); chk(d == mem_f(16'hFFFE), "R8 random read data", d, mem_f(16'hFFFE));
        recv_byte(1'b1, d); chk(d == mem_f(16'hFFFF), "R9 sequential byte", d, mem_f(16'hFFFF));
        recv_byte(1'b0, d); chk(d == mem_f(16'h0000), "R9 wrap to zero", d, mem_f(16'h0000));
        // R10: no drive after nack
        ones = 0;
        for (int i = 0; i < 9; i++) begin
            recv_bit(b);
            if (b) ones++;
        end
        chk(ones == 9, "R10 released after nack", ones, 9);
        b_stop; wt(5);
        chk(n_commit == 1, "R8 no commit on random read", n_commit, 1);

        // R9/R11: counter continues past wrap
        b_start; send_byte(DEVR, ack); recv_byte(1'b0, d); b_stop;
        chk(d == mem_f(16'h0001), "R11 counter kept across transactions", d, mem_f(16'h0001));

        // R1: start in the middle of a device byte
        b_start; send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        b_start; send_byte(DEVR, ack);
        chk(ack, "R1 mid-byte start restarts", ack, 1);
        recv_byte(1'b0, d); b_stop;
        chk(d == mem_f(16'h0002), "R1 read after abort", d, mem_f(16'h0002));

        // R3/R5: stop after only the high address byte
        b_start; send_byte(DEVW, ack); send_byte(8'h20, ack); b_stop; wt(5);
        chk(n_commit == 1, "R5 no commit on partial header", n_commit, 1);
        b_start; send_byte(DEVR, ack); recv_byte(1'b0, d); b_stop;
        chk(d == mem_f(16'h0003), "R3 partial header leaves counter", d, mem_f(16'h0003));

        chk(r12_bad == 0, "R12 drive change while SCL high", r12_bad, 0);
        chk(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule